// File: doc/BRIEF.md
# Mode-Dependent Address Sequencer

This block holds the address pointer used while a serial memory frame streams data bytes. When the front end has decoded a start address, it pulses a load strobe. The pointer takes that address and the frame is marked valid. After each complete data byte, whether read or written, the front end pulses a byte-done strobe. The pointer then moves according to a two-bit access mode.

There are three advance rules. Linear mode walks the whole 64 KB space and rolls from the top address back to zero. Page mode confines the pointer to the addressed 32-byte page. The array has 2048 such pages. In page mode the pointer wraps from the last byte of a page to the first byte of the same page, so a long write overwrites earlier bytes of that page. Single mode allows exactly one data byte: after that byte the valid flag drops, which tells the front end to ignore every further byte in the frame.

The mode is sampled at each byte-done strobe. It is not latched at load time.

Top module: `stream_addr_seq`

## Requirements
- R1: After reset, `addr_o` is 0x0000 and `valid_o` is 0.
- R2: A load strobe makes `addr_o` equal to `start_addr_i` and `valid_o` equal to 1 in the next cycle. This holds even when `byte_done_i` is high in the same cycle.
- R3: In mode 2'b01 (linear), each byte-done while valid adds 1 to `addr_o`, and 0xFFFF is followed by 0x0000.
- R4: In mode 2'b10 (page), each byte-done while valid adds 1 modulo 32 to `addr_o[4:0]` and leaves `addr_o[15:5]` unchanged. After 32 strobes the pointer is back at its start.
- R5: In mode 2'b00 (single), the first byte-done while valid clears `valid_o` and leaves `addr_o` unchanged.
- R6: While `valid_o` is 0, byte-done strobes change neither `addr_o` nor `valid_o`.
- R7: Mode 2'b11 is reserved and behaves as single mode.
- R8: In a cycle with neither strobe, `addr_o` and `valid_o` hold their values.
- R9: The advance rule is taken from `mode_i` in the cycle of each byte-done strobe. A mode change within a frame therefore affects the next advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Load the start address and open the frame |
| start_addr_i | input | 16 | Start address of the frame |
| byte_done_i | input | 1 | One full data byte has been transferred |
| mode_i | input | 2 | 00 single, 01 linear, 10 page, 11 reserved (single) |
| addr_o | output | 16 | Current pointer |
| valid_o | output | 1 | High while further data bytes of the frame are accepted |

## Verification
Both outputs come straight from one register stage, so every strobe shows its effect exactly one clock edge later. The bench drives inputs on the falling edge and checks the outputs on the following falling edge, which is one full edge after the strobe was taken. No check is made earlier and none is deferred. The vector walk and the directed page-wrap, carry and mid-run reset tests all keep to this one-cycle spacing.

// File: rtl/stream_addr_seq_pkg.sv
package stream_addr_seq_pkg;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'b00,
        MODE_LINEAR = 2'b01,
        MODE_PAGE   = 2'b10,
        MODE_RSVD   = 2'b11
    } acc_mode_e;

endpackage

// File: rtl/seq_burst_policy.sv
module seq_burst_policy
    import stream_addr_seq_pkg::*;
(
    input  logic [1:0] mode_i,
    output logic       multi_o,
    output logic       page_wrap_o
);
    acc_mode_e mode;

    always_comb begin
        mode        = acc_mode_e'(mode_i);
        multi_o     = 1'b0;
        page_wrap_o = 1'b0;
        unique case (mode)
            MODE_LINEAR: multi_o = 1'b1;
            MODE_PAGE: begin
                multi_o     = 1'b1;
                page_wrap_o = 1'b1;
            end
            default: multi_o = 1'b0;   // single and reserved
        endcase
    end
endmodule

// File: rtl/seq_addr_step.sv
module seq_addr_step #(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 5
) (
    input  logic [ADDR_W-1:0] cur_i,
    input  logic              page_wrap_i,
    output logic [ADDR_W-1:0] nxt_o
);
    logic [ADDR_W-1:0] lin_nxt;
    logic [ADDR_W-1:0] page_nxt;

    assign lin_nxt = cur_i + ADDR_W'(1);

    generate
        if (PAGE_W >= ADDR_W) begin : g_no_page
            assign page_nxt = lin_nxt;
        end else begin : g_page
            logic [PAGE_W-1:0] offs_nxt;
            assign offs_nxt = cur_i[PAGE_W-1:0] + PAGE_W'(1);
            assign page_nxt = {cur_i[ADDR_W-1:PAGE_W], offs_nxt};
        end
    endgenerate

    assign nxt_o = page_wrap_i ? page_nxt : lin_nxt;
endmodule

// File: rtl/stream_addr_seq.sv
module stream_addr_seq
    import stream_addr_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              byte_done_i,
    input  logic [1:0]        mode_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              valid_o
);
    localparam int PG_HI = (PAGE_W < ADDR_W) ? PAGE_W : ADDR_W - 1;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              valid;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic              multi;
    logic              page_wrap;
    logic [ADDR_W-1:0] step_addr;

    seq_burst_policy u_policy (
        .mode_i      (mode_i),
        .multi_o     (multi),
        .page_wrap_o (page_wrap)
    );

    seq_addr_step #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_step (
        .cur_i       (st_q.addr),
        .page_wrap_i (page_wrap),
        .nxt_o       (step_addr)
    );

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.addr  = start_addr_i;
            st_d.valid = 1'b1;
        end else if (byte_done_i && st_q.valid) begin
            if (multi) begin
                st_d.addr = step_addr;
            end else begin
                st_d.valid = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o  = st_q.addr;
    assign valid_o = st_q.valid;

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (addr_o == $past(start_addr_i)) && valid_o) else $error("AST_LOAD_WINS"); // R2
    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && byte_done_i && valid_o && mode_i == 2'b01)
        |=> (addr_o == $past(addr_o) + ADDR_W'(1)) && valid_o) else $error("AST_LINEAR_STEP"); // R3
    AST_PAGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && byte_done_i && valid_o && mode_i == 2'b10)
        |=> (addr_o[ADDR_W-1:PG_HI] == $past(addr_o[ADDR_W-1:PG_HI])) && valid_o) else $error("AST_PAGE_KEPT"); // R4
    AST_SINGLE_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && byte_done_i && valid_o && !mode_i[1] && !mode_i[0])
        |=> !valid_o && $stable(addr_o)) else $error("AST_SINGLE_CLOSE"); // R5
    AST_CLOSED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !valid_o) |=> !valid_o && $stable(addr_o)) else $error("AST_CLOSED_FROZEN"); // R6
    AST_RSVD_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && byte_done_i && valid_o && mode_i == 2'b11)
        |=> !valid_o && $stable(addr_o)) else $error("AST_RSVD_CLOSE"); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !byte_done_i) |=> $stable(addr_o) && $stable(valid_o)) else $error("AST_IDLE_HOLD"); // R8
endmodule

// File: tb/stream_addr_seq_tb_top.sv
`timescale 1ns/1ps
module stream_addr_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic [15:0] start_addr_i = '0;
    logic        byte_done_i = 1'b0;
    logic [1:0]  mode_i = 2'b01;
    logic [15:0] addr_o;
    logic        valid_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    stream_addr_seq dut_i (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .start_addr_i(start_addr_i),
        .byte_done_i(byte_done_i), .mode_i(mode_i), .addr_o(addr_o), .valid_o(valid_o)
    );

    // {load, byte_done, mode, start, exp_addr, exp_valid, requirement}
    localparam int NV = 16;
    localparam logic [40:0] VECS [NV] = '{
        {1'b1, 1'b0, 2'b01, 16'hFFFE, 16'hFFFE, 1'b1, 4'd2}, // R2
        {1'b0, 1'b1, 2'b01, 16'h0000, 16'hFFFF, 1'b1, 4'd3}, // R3
        {1'b0, 1'b1, 2'b01, 16'h0000, 16'h0000, 1'b1, 4'd3}, // R3 rollover
        {1'b0, 1'b0, 2'b01, 16'h5555, 16'h0000, 1'b1, 4'd8}, // R8
        {1'b1, 1'b0, 2'b10, 16'h123E, 16'h123E, 1'b1, 4'd2}, // R2
        {1'b0, 1'b1, 2'b10, 16'h0000, 16'h123F, 1'b1, 4'd4}, // R4
        {1'b0, 1'b1, 2'b10, 16'h0000, 16'h1220, 1'b1, 4'd4}, // R4 wrap
        {1'b0, 1'b1, 2'b10, 16'h0000, 16'h1221, 1'b1, 4'd4}, // R4
        {1'b1, 1'b1, 2'b00, 16'h4000, 16'h4000, 1'b1, 4'd2}, // R2 priority
        {1'b0, 1'b1, 2'b00, 16'h0000, 16'h4000, 1'b0, 4'd5}, // R5
        {1'b0, 1'b1, 2'b01, 16'h0000, 16'h4000, 1'b0, 4'd6}, // R6
        {1'b1, 1'b0, 2'b11, 16'h7777, 16'h7777, 1'b1, 4'd2}, // R2
        {1'b0, 1'b1, 2'b11, 16'h0000, 16'h7777, 1'b0, 4'd7}, // R7
        {1'b1, 1'b0, 2'b10, 16'h00FF, 16'h00FF, 1'b1, 4'd2}, // R2
        {1'b0, 1'b1, 2'b01, 16'h0000, 16'h0100, 1'b1, 4'd9}, // R9 linear carry
        {1'b0, 1'b1, 2'b10, 16'h0000, 16'h0101, 1'b1, 4'd9}  // R9 back to page
    };

    task automatic check(input string req, input logic [15:0] ea, input logic ev);
        checks++;
        if (addr_o !== ea || valid_o !== ev) begin
            errors++;
            $display("FAIL %s: addr=%h valid=%b expected addr=%h valid=%b",
                     req, addr_o, valid_o, ea, ev);
        end
    endtask

    // drive at falling edge, result due one rising edge later, sampled at next falling edge
    task automatic step(input logic ld, input logic bd, input logic [1:0] md, input logic [15:0] sa);
        load_i = ld; byte_done_i = bd; mode_i = md; start_addr_i = sa;
        @(negedge clk);
        load_i = 1'b0; byte_done_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 16'h0000, 1'b0);
        step(1'b0, 1'b1, 2'b01, 16'h0000);
        check("R6", 16'h0000, 1'b0);   // R6 closed after reset

        for (int i = 0; i < NV; i++) begin
            logic [40:0] v;
            v = VECS[i];
            step(v[40], v[39], v[38:37], v[36:21]);
            check($sformatf("R%0d", v[3:0]), v[20:5], v[4]);
        end

        // R4: full 32-byte page walk returns to the start
        step(1'b1, 1'b0, 2'b10, 16'hABC7);
        for (int i = 1; i <= 32; i++) begin
            step(1'b0, 1'b1, 2'b10, 16'h0000);
            check("R4", {11'h55E, 5'(5'd7 + 5'(i))}, 1'b1);
        end

        // R3: linear crosses page boundary
        step(1'b1, 1'b0, 2'b01, 16'h03FE);
        for (int i = 1; i <= 4; i++) begin
            step(1'b0, 1'b1, 2'b01, 16'h0000);
            check("R3", 16'h03FE + 16'(i), 1'b1);
        end

        // R8: idle cycles hold
        for (int i = 0; i < 3; i++) begin
            step(1'b0, 1'b0, 2'b10, 16'hFFFF);
            check("R8", 16'h0402, 1'b1);
        end

        // R1: reset mid-frame
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", 16'h0000, 1'b0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule